// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a three-wire link to a 12-bit successive-approximation converter. A single start pulse makes it pull chip select low, produce a burst of serial clock pulses from the system clock, and sample the converter's data line. The converter places two leading zeros ahead of its 12-bit result, most significant bit first. A longer frame then adds two trailing bits. The controller removes the framing bits and delivers the 12-bit word together with a one-cycle valid strobe. An error flag reports any leading-zero slot that read back as one.

The frame length (14 or 16 serial clocks), the sampling edge (falling or rising), the divider ratio and the quiet interval are runtime inputs. All of them are captured on the cycle that accepts a start. The serial clock rests low, and chip select always falls during a low phase. With falling-edge sampling, the first leading zero is seen, because the converter drives it the moment chip select falls. With rising-edge sampling, the rising edge that comes before any falling edge is thrown away. Every later rising edge then takes the bit the preceding falling edge shifted out, so the last sample arrives on the final rising edge. When the frame ends, chip select stays high for a programmable quiet interval, and starts are not taken during that time.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, valid_o is 0, zero_err_o is 0, result_o is 0 and busy_o is 0.
- R2: A start_i seen while busy_o is 0 drives cs_n_o low on the next cycle, with sclk_o low. sclk_o is never high while cs_n_o is high, and the first rising edge of sclk_o follows one full low phase.
- R3: One sclk_o period lasts div_i system clocks. The high phase is floor(div_i/2) cycles and the low phase takes the remaining cycles. A div_i of 0 or 1 behaves as 2. div_i, frame16_i, cap_rise_i and quiet_i are sampled only at the accepted start.
- R4: With frame16_i=1 a frame holds 16 sclk_o pulses, and with 0 it holds 14. cs_n_o returns high one system clock after the last falling edge of sclk_o.
- R5: With cap_rise_i=0, sdo_i is sampled on every falling edge of sclk_o. Falling edge k supplies frame bit k, and bit 1 is the level sdo_i held from the fall of cs_n_o.
- R6: With cap_rise_i=1, the rising edge of sclk_o that precedes the first falling edge is not sampled. Rising edge k (k = 2 to N) supplies frame bit k, and the final sample lands on the last rising edge of the frame.
- R7: result_o is frame bits 3 to 14, with bit 3 as the most significant bit. Bits 15 and 16 of a 16-clock frame have no effect on any output.
- R8: valid_o is high for exactly one system clock, on the cycle in which cs_n_o returns high. result_o changes only in that cycle.
- R9: zero_err_o is updated together with valid_o. It is 1 when a sampled leading-zero bit is 1: bits 1 and 2 with falling-edge sampling, bit 2 alone with rising-edge sampling. It holds its value until the next valid_o.
- R10: busy_o is high from the cycle after an accepted start through quiet_i+1 cycles that begin on the cycle cs_n_o returns high. A start_i that arrives in that window is ignored, and cs_n_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion readout |
| frame16_i | input | 1 | 1 selects the 16-clock frame, 0 selects 14 |
| cap_rise_i | input | 1 | 1 samples on rising serial clock edges, 0 on falling |
| div_i | input | DIV_W | System clocks per serial clock period |
| quiet_i | input | QUIET_W | Extra idle cycles with chip select high after a frame |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles low |
| result_o | output | 12 | Last received conversion result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| zero_err_o | output | 1 | A leading-zero slot read back as 1 |
| busy_o | output | 1 | Frame or quiet interval in progress |

## Verification
The bound checker watches the protocol invariants on every cycle. The serial clock never rises while chip select is high, chip select only falls with the clock low, and each frame carries 14 or 16 clock pulses. The strobe lasts one cycle and coincides with chip select rising, the result and error flag hold between strobes, and busy covers the whole frame. Some properties depend on what the converter actually sent, and only the directed scenarios against a bench model of the converter can show them. These are bit alignment in each sampling mode, the dropped first leading zero with rising-edge sampling, the ignored trailing bits, the exact high and low phase lengths for each divider value, and the rejection of a start during the quiet interval.

// File: rtl/adc_rdout_pkg.sv
`timescale 1ns/1ps
package adc_rdout_pkg;
  localparam int RES_W     = 12;
  localparam int LEAD_W    = 2;
  localparam int SHORT_LEN = LEAD_W + RES_W;
  localparam int LONG_LEN  = SHORT_LEN + 2;
  localparam int POS_W     = $clog2(LONG_LEN + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN,
    ST_QUIET
  } seq_st_e;
endpackage

// File: rtl/adc_sclk_gen.sv
`timescale 1ns/1ps
module adc_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic             sclk_q, sclk_d;
  logic [DIV_W-1:0] ph_q, ph_d;
  logic [DIV_W-1:0] div_eff, hi_len, lo_len, cur_len;
  logic             wrap;

  always_comb begin
    div_eff = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
    hi_len  = div_eff >> 1;
    lo_len  = div_eff - hi_len;
    cur_len = sclk_q ? hi_len : lo_len;
    wrap    = run_i && (ph_q == cur_len - DIV_W'(1));
    rise_o  = wrap && !sclk_q;
    fall_o  = wrap && sclk_q;
  end

  always_comb begin
    sclk_d = sclk_q;
    ph_d   = ph_q;
    if (!run_i) begin
      sclk_d = 1'b0;
      ph_d   = '0;
    end else if (wrap) begin
      sclk_d = !sclk_q;
      ph_d   = '0;
    end else begin
      ph_d   = ph_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ph_q   <= '0;
    end else begin
      sclk_q <= sclk_d;
      ph_q   <= ph_d;
    end
  end

  assign sclk_o = sclk_q;
endmodule

// File: rtl/adc_frame_seq.sv
`timescale 1ns/1ps
module adc_frame_seq
  import adc_rdout_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int QUIET_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               frame16_i,
  input  logic               cap_rise_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [QUIET_W-1:0] quiet_i,
  input  logic               fall_i,
  output logic               cs_n_o,
  output logic               run_o,
  output logic               busy_o,
  output logic               fin_o,
  output logic [POS_W-1:0]   fall_num_o,
  output logic               cap_rise_o,
  output logic [DIV_W-1:0]   div_o
);
  seq_st_e            st_q, st_d;
  logic               cs_n_q, cs_n_d;
  logic               run_q, run_d;
  logic [POS_W-1:0]   nfall_q, nfall_d;
  logic               f16_q, f16_d;
  logic               rise_q, rise_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic [QUIET_W-1:0] qcfg_q, qcfg_d;
  logic [QUIET_W-1:0] qcnt_q, qcnt_d;
  logic               last_fall;

  assign last_fall = (nfall_q == (f16_q ? POS_W'(LONG_LEN - 1) : POS_W'(SHORT_LEN - 1)));

  always_comb begin
    st_d    = st_q;
    cs_n_d  = cs_n_q;
    run_d   = run_q;
    nfall_d = nfall_q;
    f16_d   = f16_q;
    rise_d  = rise_q;
    div_d   = div_q;
    qcfg_d  = qcfg_q;
    qcnt_d  = qcnt_q;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_RUN;
          cs_n_d  = 1'b0;
          run_d   = 1'b1;
          nfall_d = '0;
          f16_d   = frame16_i;
          rise_d  = cap_rise_i;
          div_d   = div_i;
          qcfg_d  = quiet_i;
        end
      end
      ST_RUN: begin
        if (fall_i) begin
          nfall_d = nfall_q + POS_W'(1);
          if (last_fall) begin
            run_d = 1'b0;
            st_d  = ST_FIN;
          end
        end
      end
      ST_FIN: begin
        cs_n_d = 1'b1;
        qcnt_d = qcfg_q;
        st_d   = ST_QUIET;
      end
      ST_QUIET: begin
        if (qcnt_q == '0) st_d = ST_IDLE;
        else              qcnt_d = qcnt_q - QUIET_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cs_n_q  <= 1'b1;
      run_q   <= 1'b0;
      nfall_q <= '0;
      f16_q   <= 1'b0;
      rise_q  <= 1'b0;
      div_q   <= '0;
      qcfg_q  <= '0;
      qcnt_q  <= '0;
    end else begin
      st_q    <= st_d;
      cs_n_q  <= cs_n_d;
      run_q   <= run_d;
      nfall_q <= nfall_d;
      f16_q   <= f16_d;
      rise_q  <= rise_d;
      div_q   <= div_d;
      qcfg_q  <= qcfg_d;
      qcnt_q  <= qcnt_d;
    end
  end

  assign cs_n_o     = cs_n_q;
  assign run_o      = run_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign fin_o      = (st_q == ST_FIN);
  assign fall_num_o = nfall_q;
  assign cap_rise_o = rise_q;
  assign div_o      = div_q;
endmodule

// File: rtl/adc_capture.sv
`timescale 1ns/1ps
module adc_capture
  import adc_rdout_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_rise_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             fin_i,
  input  logic             sdo_i,
  input  logic [POS_W-1:0] fall_num_i,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o,
  output logic             zero_err_o
);
  logic [LONG_LEN-1:0] frame_q, frame_d;
  logic [LONG_LEN-1:0] slot_wr;
  logic [RES_W-1:0]    res_asm, result_q, result_d;
  logic [LEAD_W-1:0]   lead_mask;
  logic                cap_en, err_asm, err_q, err_d, valid_q, valid_d;

  // With rising-edge sampling the pre-fall rising edge (fall count 0) is dropped.
  assign cap_en = cap_rise_i ? (rise_i && (fall_num_i != '0)) : fall_i;

  for (genvar s = 0; s < LONG_LEN; s++) begin : g_slot
    assign slot_wr[s] = cap_en && (fall_num_i == POS_W'(s));
    assign frame_d[s] = slot_wr[s] ? sdo_i : frame_q[s];
  end

  for (genvar b = 0; b < RES_W; b++) begin : g_res
    assign res_asm[RES_W-1-b] = frame_q[LEAD_W+b];
  end

  // The first leading zero is only checked when it was actually sampled.
  if (LEAD_W > 1) begin : g_mask_multi
    assign lead_mask = {{(LEAD_W-1){1'b1}}, !cap_rise_i};
  end else begin : g_mask_single
    assign lead_mask = !cap_rise_i;
  end
  assign err_asm = |(frame_q[LEAD_W-1:0] & lead_mask);

  always_comb begin
    result_d = result_q;
    err_d    = err_q;
    valid_d  = 1'b0;
    if (fin_i) begin
      result_d = res_asm;
      err_d    = err_asm;
      valid_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q  <= '0;
      result_q <= '0;
      err_q    <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      frame_q  <= frame_d;
      result_q <= result_d;
      err_q    <= err_d;
      valid_q  <= valid_d;
    end
  end

  assign result_o   = result_q;
  assign zero_err_o = err_q;
  assign valid_o    = valid_q;
endmodule

// File: rtl/adc_rdout_ctrl.sv
`timescale 1ns/1ps
module adc_rdout_ctrl
  import adc_rdout_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int QUIET_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               frame16_i,
  input  logic               cap_rise_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [QUIET_W-1:0] quiet_i,
  input  logic               sdo_i,
  output logic               cs_n_o,
  output logic               sclk_o,
  output logic [RES_W-1:0]   result_o,
  output logic               valid_o,
  output logic               zero_err_o,
  output logic               busy_o
);
  logic             run, rise_ev, fall_ev, fin, cap_rise_q;
  logic [POS_W-1:0] fall_num;
  logic [DIV_W-1:0] div_q;

  adc_frame_seq #(.DIV_W(DIV_W), .QUIET_W(QUIET_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .frame16_i  (frame16_i),
    .cap_rise_i (cap_rise_i),
    .div_i      (div_i),
    .quiet_i    (quiet_i),
    .fall_i     (fall_ev),
    .cs_n_o     (cs_n_o),
    .run_o      (run),
    .busy_o     (busy_o),
    .fin_o      (fin),
    .fall_num_o (fall_num),
    .cap_rise_o (cap_rise_q),
    .div_o      (div_q)
  );

  adc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .div_i  (div_q),
    .sclk_o (sclk_o),
    .rise_o (rise_ev),
    .fall_o (fall_ev)
  );

  adc_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_rise_i (cap_rise_q),
    .rise_i     (rise_ev),
    .fall_i     (fall_ev),
    .fin_i      (fin),
    .sdo_i      (sdo_i),
    .fall_num_i (fall_num),
    .result_o   (result_o),
    .valid_o    (valid_o),
    .zero_err_o (zero_err_o)
  );
endmodule

// File: rtl/adc_rdout_chk.sv
`timescale 1ns/1ps
module adc_rdout_chk
  import adc_rdout_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             valid,
  input logic             busy,
  input logic             zero_err,
  input logic [RES_W-1:0] result
);
  logic             sclk_d;
  logic [POS_W-1:0] pulse_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      sclk_d <= sclk;
      if (cs_n)                pulse_cnt <= '0;
      else if (sclk && !sclk_d) pulse_cnt <= pulse_cnt + POS_W'(1);
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  assert_cs_fall_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sclk);
  assert_pulse_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (pulse_cnt == POS_W'(SHORT_LEN) || pulse_cnt == POS_W'(LONG_LEN)));
  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_valid_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $rose(cs_n));
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(result));
  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(zero_err));
  assert_busy_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
endmodule

bind adc_rdout_ctrl adc_rdout_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n_o),
  .sclk     (sclk_o),
  .valid    (valid_o),
  .busy     (busy_o),
  .zero_err (zero_err_o),
  .result   (result_o)
);

// File: tb/adc_rdout_ctrl_tb.sv
`timescale 1ns/1ps
module adc_rdout_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, frame16_i, cap_rise_i;
  logic [7:0]  div_i, quiet_i;
  logic        sdo;
  logic        cs_n_o, sclk_o, valid_o, zero_err_o, busy_o;
  logic [11:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Converter model: bit k of the frame is bits_m[k-1].
  logic [15:0] bits_m = '0;
  int          idx_m  = 0;

  always #2.5 clk = !clk;

  adc_rdout_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame16_i(frame16_i),
    .cap_rise_i(cap_rise_i), .div_i(div_i), .quiet_i(quiet_i), .sdo_i(sdo),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .result_o(result_o), .valid_o(valid_o),
    .zero_err_o(zero_err_o), .busy_o(busy_o)
  );

  always @(negedge cs_n_o) begin
    #1;
    idx_m = 0;
    sdo   = bits_m[0];
  end

  always @(negedge sclk_o) begin
    if (!cs_n_o) begin
      #1;
      idx_m = idx_m + 1;
      sdo   = (idx_m < 16) ? bits_m[idx_m] : 1'b0;
    end
  end

  always @(posedge cs_n_o) begin
    #1;
    sdo = 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_bits(input bit z1, input bit z2, input logic [11:0] data,
                           input logic [1:0] trail);
    bits_m[0] = z1;
    bits_m[1] = z2;
    for (int i = 0; i < 12; i++) bits_m[2+i] = data[11-i];
    bits_m[14] = trail[1];
    bits_m[15] = trail[0];
  endtask

  task automatic t_reset_state();
    chk("R1 cs_n", cs_n_o, 1);
    chk("R1 sclk", sclk_o, 0);
    chk("R1 valid", valid_o, 0);
    chk("R1 err", zero_err_o, 0);
    chk("R1 result", result_o, 0);
    chk("R1 busy", busy_o, 0);
  endtask

  task automatic wait_idle();
    int g = 0;
    while ((busy_o || !cs_n_o) && g < 5000) begin
      @(negedge clk);
      g++;
    end
    chk("R10 returns idle", int'(g < 5000), 1);
  endtask

  // R3 and R2: phase lengths measured in system clocks.
  task automatic t_div_shape(input int div, input int exp_lo, input int exp_hi);
    int lo = 0, hi = 0, lo2 = 0;
    load_bits(0, 0, 12'h000, 2'b00);
    @(negedge clk);
    frame16_i = 0; cap_rise_i = 0; div_i = 8'(div); quiet_i = 0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R2 cs_n low after start", cs_n_o, 0);
    while (!sclk_o && lo < 100) begin lo++; @(negedge clk); end
    while (sclk_o && hi < 100) begin hi++; @(negedge clk); end
    while (!sclk_o && lo2 < 100) begin lo2++; @(negedge clk); end
    chk($sformatf("R2 first low phase div=%0d", div), lo, exp_lo);
    chk($sformatf("R3 high phase div=%0d", div), hi, exp_hi);
    chk($sformatf("R3 low phase div=%0d", div), lo2, exp_lo);
    wait_idle();
  endtask

  task automatic t_frame(input bit f16, input bit rise, input int div, input int quiet,
                         input bit z1, input bit z2, input logic [11:0] data,
                         input logic [1:0] trail, input bit flip_cfg, input bit poke);
    int rises = 0, g = 0, b = 0;
    bit prev, csl = 0;
    bit exp_err;
    load_bits(z1, z2, data, trail);
    exp_err = rise ? z2 : (z1 | z2);
    @(negedge clk);
    frame16_i = f16; cap_rise_i = rise; div_i = 8'(div); quiet_i = 8'(quiet); start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (flip_cfg) begin
      frame16_i = !f16; div_i = 8'd9; quiet_i = 8'd40; cap_rise_i = !rise;
    end
    chk("R2 cs_n low", cs_n_o, 0);
    chk("R2 sclk low at cs fall", sclk_o, 0);
    prev = sclk_o;
    while (!valid_o && g < 20000) begin
      @(negedge clk);
      if (sclk_o && !prev) rises++;
      prev = sclk_o;
      g++;
    end
    chk("R8 valid seen", valid_o, 1);
    chk("R4 pulse count", rises, f16 ? 16 : 14);
    chk("R8 cs_n high with valid", cs_n_o, 1);
    chk(rise ? "R6 result rising" : "R5 result falling", result_o, data);
    chk("R7 result bits 3-14", result_o, data);
    chk("R9 zero error", zero_err_o, exp_err);
    while (busy_o && b < 1000) begin
      b++;
      start_i = (poke && b == 2);
      @(negedge clk);
      if (b == 1) chk("R8 valid one cycle", valid_o, 0);
      if (!cs_n_o) csl = 1;
    end
    start_i = 0;
    chk("R10 busy span", b, quiet + 1);
    chk("R10 cs_n high in quiet", csl, 0);
    @(negedge clk);
    chk("R10 start in quiet ignored", cs_n_o, 1);
    chk("R9 err held", zero_err_o, exp_err);
    chk("R8 result held", result_o, data);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; frame16_i = 0; cap_rise_i = 0;
    div_i = 8'd2; quiet_i = 0; sdo = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    // R5 falling, 14-clock
    t_frame(0, 0, 2, 0, 0, 0, 12'hA5C, 2'b00, 0, 0);
    // R7 16-clock with trailing ones ignored
    t_frame(1, 0, 4, 1, 0, 0, 12'h3F1, 2'b11, 0, 0);
    // R6 rising, first leading zero slot set to 1 and ignored
    t_frame(0, 1, 3, 0, 1, 0, 12'h96A, 2'b00, 0, 0);
    // R6 rising, 16-clock, last bit on final rising edge
    t_frame(1, 1, 2, 2, 0, 0, 12'hC35, 2'b11, 0, 0);
    t_frame(1, 1, 5, 0, 1, 0, 12'h001, 2'b10, 0, 0);
    // R9 error cases
    t_frame(0, 0, 2, 0, 1, 0, 12'h5A5, 2'b00, 0, 0);
    t_frame(1, 0, 3, 0, 0, 1, 12'h7E8, 2'b00, 0, 0);
    t_frame(0, 1, 2, 0, 0, 1, 12'h123, 2'b00, 0, 0);
    // R10 start during quiet interval
    t_frame(0, 0, 2, 6, 0, 0, 12'h0F0, 2'b00, 0, 1);
    // R3 configuration captured at start
    t_frame(0, 0, 2, 0, 0, 0, 12'hE19, 2'b00, 1, 0);
    cap_rise_i = 0; quiet_i = 0;
    // R3 divider shapes
    t_div_shape(5, 3, 2);
    t_div_shape(2, 1, 1);
    t_div_shape(0, 1, 1);
    t_div_shape(1, 1, 1);
    t_div_shape(7, 4, 3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule